// File: doc/BRIEF.md
# Single-Car Elevator Scheduling Controller

This controller runs one elevator car over five floors. Calls from the landings and calls from the panel inside the car are each held as one bit per floor. A bit is set by a one-cycle strobe and stays set until the car has served that floor. The controller holds the current floor and a travel direction. A scan state machine walks an index through the floors to pick the next stop. It then commands the motor until the floor sensor reports arrival, and holds the car for a door dwell before it searches again.

Pending calls fall into two pools. Floors at or beyond the car in its travel direction can be served on the way and form the active pool. Floors behind the car form the deferred pool. When the active pool is empty and the deferred pool is not, the direction bit flips, so the two pools trade roles. When no call is pending, the car rests in a home state with the motor off.

Top module: `elev_ctrl`

## Requirements
- R1: While reset is held and right after it, motor_on is 0, motor_up is 0 (direction down) and next_floor is 0 (the car is taken to be at floor 0).
- R2: A 1 on bit i of hall_call or car_call for one clock latches a call for floor i. Both kinds of call are kept until that floor is served, and both lead to the same service.
- R3: If a strobe sets floor i in the same cycle that the controller clears floor i on arrival, the call survives. The car serves floor i again before it departs for any other floor.
- R4: From floor c, moving up, the next stop is the lowest pending floor f >= c. Moving down, it is the highest pending floor f <= c. Pending floors behind the car wait.
- R5: When no pending floor lies at or beyond the car in its direction but calls remain, the direction reverses and the remaining calls are served in the new direction.
- R6: While the car travels, motor_on is 1 and next_floor is the target. motor_up is 1 exactly when the target is above the floor the car left (1 = up, 0 = down).
- R7: During travel, when floor_pos equals next_floor, motor_on is 0 from the next cycle on. Both the hall and the car call for that floor are cleared.
- R8: After each arrival, the motor stays off for more than DWELL_CYCLES cycles before the next departure.
- R9: With no call pending, the controller rests with motor_on 0 and next_floor equal to the floor the car is at.
- R10: floor_pos values other than the target are ignored. Passing floors during travel and sensor changes while idle neither stop nor start the motor.
- R11: A call for the floor the car is at is served with a dwell and no motor movement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_call | input | NUM_FLOORS | Per-floor landing call strobes |
| car_call | input | NUM_FLOORS | Per-floor in-car call strobes |
| floor_pos | input | FW | Floor reported by the car position sensor |
| motor_on | output | 1 | Motor run command |
| motor_up | output | 1 | Motor direction, 1 = up |
| next_floor | output | FW | Floor the car is heading to, or resting at |

## Verification
Two functions can fall in the same cycle. One is the arrival clear of a floor's call bits. The other is a fresh call strobe for that same floor. The bench provokes this by pulsing a landing call for the target floor on the same clock edge that the sensor first reports that floor. It judges the result at the ports: the gap from that arrival to the next departure must cover a second dwell, because the surviving call is served at the same floor first. Random call patterns run the collision at random floors, and a reference scan order in the bench predicts every departure target and direction.

// File: rtl/elev_pkg.sv
package elev_pkg;
  typedef enum logic [2:0] {
    ST_HOME   = 3'd0,
    ST_FIND   = 3'd1,
    ST_ASSIGN = 3'd2,
    ST_DWELL  = 3'd3,
    ST_TRAVEL = 3'd4
  } car_state_e;
endpackage

// File: rtl/elev_req_bank.sv
module elev_req_bank #(
  parameter int NUM_FLOORS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FLOORS-1:0] set_i,
  input  logic [NUM_FLOORS-1:0] clr_i,
  output logic [NUM_FLOORS-1:0] q_o
);
  // one set/clear latch per floor, set has priority
  for (genvar g = 0; g < NUM_FLOORS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_o[g] <= 1'b0;
      else if (set_i[g])   q_o[g] <= 1'b1;
      else if (clr_i[g])   q_o[g] <= 1'b0;
    end
  end

  // R3
  set_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/elev_pool_split.sv
module elev_pool_split #(
  parameter int NUM_FLOORS = 5,
  parameter int FW         = 3
) (
  input  logic [NUM_FLOORS-1:0] req_i,
  input  logic [FW-1:0]         cur_i,
  input  logic                  up_i,
  output logic [NUM_FLOORS-1:0] active_o,
  output logic [NUM_FLOORS-1:0] deferred_o
);
  for (genvar g = 0; g < NUM_FLOORS; g++) begin : g_floor
    localparam logic [FW-1:0] FLOOR = FW'(g);
    logic ahead;
    assign ahead         = up_i ? (FLOOR >= cur_i) : (FLOOR <= cur_i);
    assign active_o[g]   = req_i[g] &  ahead;
    assign deferred_o[g] = req_i[g] & ~ahead;
  end
endmodule

// File: rtl/elev_dwell_timer.sv
module elev_dwell_timer #(
  parameter int DWELL_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(DWELL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DWELL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/elev_ctrl.sv
module elev_ctrl #(
  parameter int NUM_FLOORS   = 5,
  parameter int DWELL_CYCLES = 8,
  localparam int FW = (NUM_FLOORS > 1) ? $clog2(NUM_FLOORS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FLOORS-1:0] hall_call,
  input  logic [NUM_FLOORS-1:0] car_call,
  input  logic [FW-1:0]         floor_pos,
  output logic                  motor_on,
  output logic                  motor_up,
  output logic [FW-1:0]         next_floor
);
  import elev_pkg::*;

  localparam logic [FW-1:0] TOP_FLOOR = FW'(NUM_FLOORS - 1);

  car_state_e state_q, state_d;
  logic [FW-1:0] idx_q, idx_d;
  logic [FW-1:0] tgt_q, tgt_d;
  logic [FW-1:0] cur_q, cur_d;
  logic          dir_q, dir_d;

  logic [NUM_FLOORS-1:0] hall_q, car_q, req_all, clr_vec;
  logic [NUM_FLOORS-1:0] active_v, deferred_v;
  logic [FW-1:0]         scan_floor;
  logic                  last_idx, hit, arrive, dwell_done;

  elev_req_bank #(.NUM_FLOORS(NUM_FLOORS)) u_hall (
    .clk(clk), .rst_n(rst_n), .set_i(hall_call), .clr_i(clr_vec), .q_o(hall_q));

  elev_req_bank #(.NUM_FLOORS(NUM_FLOORS)) u_car (
    .clk(clk), .rst_n(rst_n), .set_i(car_call), .clr_i(clr_vec), .q_o(car_q));

  assign req_all = hall_q | car_q;

  elev_pool_split #(.NUM_FLOORS(NUM_FLOORS), .FW(FW)) u_pool (
    .req_i(req_all), .cur_i(cur_q), .up_i(dir_q),
    .active_o(active_v), .deferred_o(deferred_v));

  elev_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_dwell (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_DWELL), .done_o(dwell_done));

  // scan order follows the direction: ascending when up, descending when down
  assign scan_floor = dir_q ? idx_q : (TOP_FLOOR - idx_q);
  assign last_idx   = (idx_q == TOP_FLOOR);
  assign hit        = active_v[scan_floor];

  assign arrive  = ((state_q == ST_ASSIGN) && (tgt_q == cur_q)) ||
                   ((state_q == ST_TRAVEL) && (floor_pos == tgt_q));
  assign clr_vec = arrive ? (NUM_FLOORS'(1) << tgt_q) : '0;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    tgt_d   = tgt_q;
    cur_d   = cur_q;
    dir_d   = dir_q;
    unique case (state_q)
      ST_HOME: begin
        tgt_d = cur_q;
        if (|req_all) begin
          state_d = ST_FIND;
          idx_d   = '0;
        end
      end
      ST_FIND: begin
        if (hit) begin
          tgt_d   = scan_floor;
          state_d = ST_ASSIGN;
        end else if (last_idx) begin
          idx_d = '0;
          if (|req_all) dir_d   = ~dir_q;
          else          state_d = ST_HOME;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_ASSIGN: state_d = (tgt_q == cur_q) ? ST_DWELL : ST_TRAVEL;
      ST_TRAVEL: begin
        if (floor_pos == tgt_q) begin
          cur_d   = tgt_q;
          state_d = ST_DWELL;
        end
      end
      ST_DWELL: begin
        if (dwell_done) begin
          state_d = ST_FIND;
          idx_d   = '0;
        end
      end
      default: state_d = ST_HOME;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOME;
      idx_q   <= '0;
      tgt_q   <= '0;
      cur_q   <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      tgt_q   <= tgt_d;
      cur_q   <= cur_d;
      dir_q   <= dir_d;
    end
  end

  assign motor_on   = (state_q == ST_TRAVEL);
  assign motor_up   = dir_q;
  assign next_floor = (state_q == ST_HOME) ? cur_q : tgt_q;

  // checker state: cycles since the last arrival, saturating
  localparam int GW = $clog2(DWELL_CYCLES + 2);
  localparam logic [GW-1:0] GAP_SAT = GW'(DWELL_CYCLES + 1);
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gap_q <= GAP_SAT;
    else if (arrive)          gap_q <= '0;
    else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
  end

  // R4
  pools_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((active_v & deferred_v) == '0) && ((active_v | deferred_v) == req_all));

  // R5
  reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIND && !hit && last_idx && (|req_all)) |=> (dir_q != $past(dir_q)));

  // R6
  travel_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAVEL) |-> (motor_up == (tgt_q > cur_q)));

  // R7
  arrive_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_on && floor_pos == next_floor) |=> !motor_on);

  // R8
  dwell_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_on) |-> (gap_q >= GW'(DWELL_CYCLES)));
endmodule

// File: tb/tb_elev_ctrl.sv
`timescale 1ns/1ps
module tb_elev_ctrl;
  localparam int NF = 5;
  localparam int DW = 8;
  localparam int FW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF-1:0] hall_call, car_call;
  logic [FW-1:0] floor_pos;
  logic          motor_on, motor_up;
  logic [FW-1:0] next_floor;

  elev_ctrl #(.NUM_FLOORS(NF), .DWELL_CYCLES(DW)) dut (
    .clk(clk), .rst_n(rst_n), .hall_call(hall_call), .car_call(car_call),
    .floor_pos(floor_pos), .motor_on(motor_on), .motor_up(motor_up),
    .next_floor(next_floor));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  int exp_cur = 0;
  bit exp_up  = 0;
  logic [NF-1:0] exp_req = '0;
  int arr_cyc = -1000;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pick(input logic [NF-1:0] req, input int cur, inout bit up);
    int f = -1;
    for (int pass = 0; pass < 2 && f < 0; pass++) begin
      if (up) begin
        for (int i = cur; i < NF; i++) if (req[i] && f < 0) f = i;
      end else begin
        for (int i = cur; i >= 0; i--) if (req[i] && f < 0) f = i;
      end
      if (f < 0) up = !up;
    end
    return f;
  endfunction

  task automatic serve(input int collide);
    bit after_col = 0;
    while (exp_req != '0) begin
      int f = pick(exp_req, exp_cur, exp_up);
      exp_req[f] = 1'b0;
      if (f != exp_cur) begin
        int w = 0;
        int step = exp_up ? 1 : -1;
        while (!motor_on && w < 300) begin @(negedge clk); w++; end
        chk(motor_on, "R4 departure", motor_on, 1);
        if (after_col) chk((cyc - arr_cyc) >= 2*DW, "R3 second dwell", cyc - arr_cyc, 2*DW);
        else           chk((cyc - arr_cyc) > DW, "R8 dwell gap", cyc - arr_cyc, DW + 1);
        after_col = 0;
        chk(next_floor == f, "R4 target", next_floor, f);
        chk(motor_up == exp_up, "R6 direction", motor_up, exp_up);
        for (int p = exp_cur + step; p != f; p += step) begin
          floor_pos = FW'(p);
          @(negedge clk);
          chk(motor_on, "R10 passing floor", motor_on, 1);
        end
        repeat ($urandom_range(0, 2)) @(negedge clk);
        floor_pos = FW'(f);
        if (f == collide) hall_call[f] = 1'b1;
        arr_cyc = cyc;
        @(negedge clk);
        hall_call = '0;
        chk(!motor_on, "R7 stop on arrival", motor_on, 0);
        if (f == collide) begin
          exp_req[f] = 1'b1;
          after_col = 1;
        end
      end
      exp_cur = f;
    end
    repeat (40) @(negedge clk);
    chk(!motor_on, "R9 idle motor", motor_on, 0);
    chk(next_floor == exp_cur, "R9 idle floor", next_floor, exp_cur);
  endtask

  task automatic request(input logic [NF-1:0] h, input logic [NF-1:0] c, input int collide);
    hall_call = h;
    car_call  = c;
    @(negedge clk);
    hall_call = '0;
    car_call  = '0;
    exp_req = h | c;
    serve(collide);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    bit seen;
    void'($urandom(32'd4711));
    rst_n = 1'b0; hall_call = '0; car_call = '0; floor_pos = '0;
    repeat (3) @(negedge clk);
    chk(!motor_on, "R1 reset motor", motor_on, 0);
    chk(!motor_up, "R1 reset direction", motor_up, 0);
    chk(next_floor == 0, "R1 reset floor", next_floor, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!motor_on && next_floor == 0, "R1 after release", next_floor, 0);

    // R2 landing call only, then in-car call only (R5 reverses from down)
    request(5'b01000, 5'b00000, -1);
    request(5'b00000, 5'b00010, -1);

    // R11 call at the current floor
    car_call[exp_cur] = 1'b1;
    @(negedge clk);
    car_call = '0;
    seen = 0;
    repeat (30) begin @(negedge clk); if (motor_on) seen = 1; end
    chk(!seen, "R11 no movement", seen, 0);
    chk(next_floor == exp_cur, "R11 floor", next_floor, exp_cur);

    // R3 collision of new call and arrival clear
    request(5'b00100, 5'b10000, 2);

    // R10 sensor wiggle while idle
    seen = 0;
    repeat (10) begin
      floor_pos = FW'($urandom_range(0, NF-1));
      @(negedge clk);
      if (motor_on) seen = 1;
    end
    floor_pos = FW'(exp_cur);
    chk(!seen, "R10 idle sensor", seen, 0);
    chk(next_floor == exp_cur, "R10 idle floor", next_floor, exp_cur);

    // R5 car at top, calls behind
    request(5'b10000, 5'b00000, -1);
    request(5'b00101, 5'b00000, -1);

    for (int s = 0; s < 40; s++) begin
      logic [NF-1:0] h = NF'($urandom);
      logic [NF-1:0] c = NF'($urandom);
      int col = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, NF-1)) : -1;
      request(h, c, col);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule